// File: doc/BRIEF.md
# Hint-Driven Instruction Prefetch Engine

This block turns software prefetch hints into line-sized requests to the next cache level. A hint carries a byte address and a type. A burst hint covers a fixed run of consecutive lines, two by default. A stream hint keeps walking forward line by line until the front end reports a taken branch. Before a line is requested, its address is offered on a dedicated probe port to the instruction-cache tags. Only a probe that reports a miss becomes a request.

Every request reserves one entry of a small streaming buffer, eight lines by default. Returned lines fill those reservations strictly in the order they were made. The fetch path looks the buffer up by address and gets a hit together with the whole line. It releases the oldest entry with a pop once that entry is filled. While every entry is reserved, the engine holds its position and stops probing until a pop frees space.

Top module: `hint_prefetch_engine`

## Requirements
- R1: While reset is asserted and right after it is released, `probe_valid`, `req_valid` and `lk_hit` are low and the buffer holds no entries.
- R2: A hint with `hint_stream`=0 probes exactly BURST_LINES consecutive lines, one per cycle, starting in the cycle after the hint with the hint address rounded down to a line boundary.
- R3: A hint with `hint_stream`=1 probes successive lines, one per cycle, until `br_taken` is seen; from the next cycle on it probes nothing more. `br_taken` has no effect on a burst.
- R4: `req_valid` is raised only in a cycle where a probe is issued and `probe_miss` is high, with `req_addr` equal to `probe_addr`. A probe that hits advances to the next line without reserving an entry.
- R5: A hint that arrives while a burst or stream is active replaces it; the next probe is for the new hint's line.
- R6: Entries are reserved in request order, and each `ret_valid` fills the oldest reserved entry that is still unfilled. A return that arrives while no entry is waiting for data is ignored.
- R7: While all DEPTH entries are reserved, no probe or request is issued and the next line address is held; issuing resumes in the cycle after a pop frees an entry.
- R8: `pop` releases the oldest entry only if that entry is filled; otherwise `pop` is ignored. A released entry no longer hits.
- R9: `lk_hit` is high only when a filled entry's line address equals `lk_addr` with its low log2(LINE_BYTES) offset bits ignored, and `lk_data` then equals the line returned for that entry. Reserved but unfilled entries do not hit.
- R10: The line address counts modulo 2^ADDR_W, so a sequence that starts at the top line continues at address zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hint_valid | input | 1 | A new prefetch hint is presented |
| hint_addr | input | ADDR_W | Byte address of the first line to prefetch |
| hint_stream | input | 1 | 1: open-ended stream, 0: fixed burst |
| br_taken | input | 1 | A taken branch was seen; ends a stream |
| probe_valid | output | 1 | Tag probe issued this cycle |
| probe_addr | output | ADDR_W | Line-aligned address being probed |
| probe_miss | input | 1 | Same-cycle probe answer: line not in the instruction cache |
| req_valid | output | 1 | Line request to the next level this cycle |
| req_addr | output | ADDR_W | Line-aligned address of the request |
| ret_valid | input | 1 | Returned line is presented |
| ret_data | input | 8*LINE_BYTES | Returned line contents |
| lk_addr | input | ADDR_W | Fetch-path lookup address |
| lk_hit | output | 1 | Lookup address found in a filled entry |
| lk_data | output | 8*LINE_BYTES | Line contents of the hit entry |
| pop | input | 1 | Release the oldest entry if it is filled |

## Verification
The bench builds the engine with a 12-bit address, 4-byte lines, a 4-entry buffer and 2-line bursts. With 1024 lines, a sweep of burst start points reaches the wrap from the top line to zero. With four entries, a single stream fills the buffer within a few cycles, so stall, ignored-pop and resume behaviour are all reached quickly. The probe stub marks none, the even lines, the odd lines or all lines as cached. Every pattern of hit and miss within a burst therefore occurs, and the expected requests and line contents are computed from the line number.

// File: rtl/hpe_pkg.sv
package hpe_pkg;
   typedef enum logic [1:0] {
      PF_IDLE   = 2'd0,
      PF_BURST  = 2'd1,
      PF_STREAM = 2'd2
   } pf_mode_e;
endpackage

// File: rtl/hpe_seq.sv
module hpe_seq
   import hpe_pkg::*;
#(
   parameter int LA_W        = 27,
   parameter int BURST_LINES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hint_valid,
   input  logic [LA_W-1:0] hint_line,
   input  logic            hint_stream,
   input  logic            br_taken,
   input  logic            stall,
   output logic            probe_valid,
   output logic [LA_W-1:0] probe_line,
   output pf_mode_e        mode
);
   localparam int LW = $clog2(BURST_LINES + 1);

   pf_mode_e        mode_q;
   logic [LA_W-1:0] line_q;
   logic [LW-1:0]   left_q;

   assign probe_valid = (mode_q != PF_IDLE) && !stall;
   assign probe_line  = line_q;
   assign mode        = mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= PF_IDLE;
         line_q <= '0;
         left_q <= '0;
      end else if (hint_valid) begin
         line_q <= hint_line;
         mode_q <= hint_stream ? PF_STREAM : PF_BURST;
         left_q <= LW'(BURST_LINES);
      end else begin
         if (probe_valid) begin
            line_q <= line_q + LA_W'(1);
            if (mode_q == PF_BURST) left_q <= left_q - LW'(1);
         end
         if (mode_q == PF_STREAM && br_taken)
            mode_q <= PF_IDLE;
         else if (mode_q == PF_BURST && probe_valid && left_q == LW'(1))
            mode_q <= PF_IDLE;
      end
   end
endmodule

// File: rtl/hpe_buf.sv
module hpe_buf #(
   parameter int LA_W   = 27,
   parameter int DATA_W = 256,
   parameter int DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc,
   input  logic [LA_W-1:0]   alloc_line,
   input  logic              ret_valid,
   input  logic [DATA_W-1:0] ret_data,
   input  logic              pop,
   input  logic [LA_W-1:0]   lk_line,
   output logic              full,
   output logic              lk_hit,
   output logic [DATA_W-1:0] lk_data
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = PW + 1;

   logic [LA_W-1:0]   tag_q [DEPTH];
   logic [DATA_W-1:0] dat_q [DEPTH];
   logic [DEPTH-1:0]  fill_q;
   logic [DEPTH-1:0]  hit_vec;
   logic [PW-1:0]     wr_q, fl_q, rd_q;
   logic [CW-1:0]     occ_q, pend_q;
   logic              do_alloc, do_fill, do_pop;

   assign full     = (occ_q == CW'(DEPTH));
   assign do_alloc = alloc && !full;
   assign do_fill  = ret_valid && (pend_q != '0);
   assign do_pop   = pop && fill_q[rd_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q   <= '0;
         fl_q   <= '0;
         rd_q   <= '0;
         occ_q  <= '0;
         pend_q <= '0;
         fill_q <= '0;
      end else begin
         if (do_alloc) wr_q <= wr_q + PW'(1);
         if (do_fill) begin
            fl_q         <= fl_q + PW'(1);
            fill_q[fl_q] <= 1'b1;
         end
         if (do_pop) begin
            rd_q         <= rd_q + PW'(1);
            fill_q[rd_q] <= 1'b0;
         end
         occ_q  <= occ_q + CW'(do_alloc) - CW'(do_pop);
         pend_q <= pend_q + CW'(do_alloc) - CW'(do_fill);
      end
   end

   always_ff @(posedge clk) begin
      if (do_alloc) tag_q[wr_q] <= alloc_line;
      if (do_fill)  dat_q[fl_q] <= ret_data;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      assign hit_vec[i] = fill_q[i] && (tag_q[i] == lk_line);
   end

   assign lk_hit = |hit_vec;

   always_comb begin
      lk_data = '0;
      for (int i = DEPTH - 1; i >= 0; i--)
         if (hit_vec[i]) lk_data = dat_q[i];
   end
endmodule

// File: rtl/hint_prefetch_engine.sv
module hint_prefetch_engine
   import hpe_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int LINE_BYTES  = 32,
   parameter int DEPTH       = 8,
   parameter int BURST_LINES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    hint_valid,
   input  logic [ADDR_W-1:0]       hint_addr,
   input  logic                    hint_stream,
   input  logic                    br_taken,
   output logic                    probe_valid,
   output logic [ADDR_W-1:0]       probe_addr,
   input  logic                    probe_miss,
   output logic                    req_valid,
   output logic [ADDR_W-1:0]       req_addr,
   input  logic                    ret_valid,
   input  logic [8*LINE_BYTES-1:0] ret_data,
   input  logic [ADDR_W-1:0]       lk_addr,
   output logic                    lk_hit,
   output logic [8*LINE_BYTES-1:0] lk_data,
   input  logic                    pop
);
   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int LA_W   = ADDR_W - OFF_W;
   localparam int DATA_W = 8 * LINE_BYTES;

   if (LINE_BYTES < 2 || (1 << OFF_W) != LINE_BYTES) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 2");
   end
   if (DEPTH < 2 || (1 << $clog2(DEPTH)) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (BURST_LINES < 1) begin : g_bad_burst
      $error("BURST_LINES must be at least 1");
   end
   if (LA_W < 2) begin : g_bad_addr
      $error("ADDR_W too small for LINE_BYTES");
   end

   pf_mode_e        seq_mode;
   logic [LA_W-1:0] probe_line;
   logic            buf_full;
   logic            unused_offsets;

   assign unused_offsets = ^{hint_addr[OFF_W-1:0], lk_addr[OFF_W-1:0]};

   hpe_seq #(
      .LA_W(LA_W),
      .BURST_LINES(BURST_LINES)
   ) seq_i (
      .clk(clk),
      .rst_n(rst_n),
      .hint_valid(hint_valid),
      .hint_line(hint_addr[ADDR_W-1:OFF_W]),
      .hint_stream(hint_stream),
      .br_taken(br_taken),
      .stall(buf_full),
      .probe_valid(probe_valid),
      .probe_line(probe_line),
      .mode(seq_mode)
   );

   assign probe_addr = {probe_line, {OFF_W{1'b0}}};
   assign req_valid  = probe_valid && probe_miss;
   assign req_addr   = probe_addr;

   hpe_buf #(
      .LA_W(LA_W),
      .DATA_W(DATA_W),
      .DEPTH(DEPTH)
   ) buf_i (
      .clk(clk),
      .rst_n(rst_n),
      .alloc(req_valid),
      .alloc_line(probe_line),
      .ret_valid(ret_valid),
      .ret_data(ret_data),
      .pop(pop),
      .lk_line(lk_addr[ADDR_W-1:OFF_W]),
      .full(buf_full),
      .lk_hit(lk_hit),
      .lk_data(lk_data)
   );
endmodule

// File: rtl/hpe_checker.sv
module hpe_checker
   import hpe_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic                               hint_valid,
   input logic [ADDR_W-$clog2(LINE_BYTES)-1:0] hint_line,
   input logic                               br_taken,
   input logic                               probe_valid,
   input logic [ADDR_W-1:0]                  probe_addr,
   input logic                               buf_full,
   input pf_mode_e                           seq_mode
);
   localparam int OFF_W = $clog2(LINE_BYTES);

   // R1
   idle_in_reset_chk: assert property (@(posedge clk) !rst_n |-> !probe_valid);

   // R7
   no_probe_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_full |-> !probe_valid);

   // R3
   stream_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_mode == PF_STREAM && br_taken && !hint_valid) |=> !probe_valid);

   // R5
   hint_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hint_valid |=> probe_addr[ADDR_W-1:OFF_W] == $past(hint_line));

   // R10
   line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (probe_valid && !hint_valid) |=>
         (!probe_valid || probe_addr == ADDR_W'($past(probe_addr) + ADDR_W'(LINE_BYTES))));
endmodule

bind hint_prefetch_engine hpe_checker #(
   .ADDR_W(ADDR_W),
   .LINE_BYTES(LINE_BYTES)
) chk_i (
   .clk(clk),
   .rst_n(rst_n),
   .hint_valid(hint_valid),
   .hint_line(hint_addr[ADDR_W-1:OFF_W]),
   .br_taken(br_taken),
   .probe_valid(probe_valid),
   .probe_addr(probe_addr),
   .buf_full(buf_full),
   .seq_mode(seq_mode)
);

// File: tb/hint_prefetch_engine_tb_top.sv
module hint_prefetch_engine_tb_top;
   localparam int AW = 12;
   localparam int LB = 4;
   localparam int DP = 4;
   localparam int DW = 8 * LB;
   localparam int NLINES = 1 << (AW - 2);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hint_valid = 1'b0;
   logic [AW-1:0] hint_addr = '0;
   logic          hint_stream = 1'b0;
   logic          br_taken = 1'b0;
   logic          probe_valid;
   logic [AW-1:0] probe_addr;
   logic          probe_miss;
   logic          req_valid;
   logic [AW-1:0] req_addr;
   logic          ret_valid = 1'b0;
   logic [DW-1:0] ret_data = '0;
   logic [AW-1:0] lk_addr = '0;
   logic          lk_hit;
   logic [DW-1:0] lk_data;
   logic          pop = 1'b0;

   int cmode = 0;
   int checks = 0;
   int failures = 0;
   int nreq = 0;
   int nprobe = 0;
   int reqs [64];
   bit done = 1'b0;

   always #10 clk = ~clk;

   function automatic bit cached(int line);
      case (cmode)
         1: return (line % 2) == 0;
         2: return (line % 2) == 1;
         3: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [DW-1:0] dat_of(int line);
      return 32'(line * 40503) ^ 32'h5A5A_3C3C;
   endfunction

   assign probe_miss = !cached(int'(probe_addr[AW-1:2]));

   hint_prefetch_engine #(
      .ADDR_W(AW),
      .LINE_BYTES(LB),
      .DEPTH(DP),
      .BURST_LINES(2)
   ) dut_i (
      .clk(clk), .rst_n(rst_n),
      .hint_valid(hint_valid), .hint_addr(hint_addr), .hint_stream(hint_stream),
      .br_taken(br_taken),
      .probe_valid(probe_valid), .probe_addr(probe_addr), .probe_miss(probe_miss),
      .req_valid(req_valid), .req_addr(req_addr),
      .ret_valid(ret_valid), .ret_data(ret_data),
      .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data),
      .pop(pop)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (probe_valid) nprobe++;
         if (req_valid) begin
            if (nreq < 64) reqs[nreq] = int'(req_addr);
            nreq++;
         end
      end
   end

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      hint_valid = 1'b0; br_taken = 1'b0; ret_valid = 1'b0; pop = 1'b0;
      idle(2);
      rst_n = 1'b1;
      idle(1);
   endtask

   task automatic clear_log();
      @(negedge clk);
      #2;
      nreq = 0;
      nprobe = 0;
   endtask

   task automatic do_hint(input int addr, input bit stream);
      @(negedge clk);
      hint_valid = 1'b1; hint_addr = AW'(addr); hint_stream = stream;
      @(negedge clk);
      hint_valid = 1'b0;
   endtask

   task automatic ret_line(input int line);
      @(negedge clk);
      ret_valid = 1'b1; ret_data = dat_of(line);
      @(negedge clk);
      ret_valid = 1'b0;
   endtask

   task automatic pop_one();
      @(negedge clk);
      pop = 1'b1;
      @(negedge clk);
      pop = 1'b0;
   endtask

   task automatic br_pulse();
      @(negedge clk);
      br_taken = 1'b1;
      @(negedge clk);
      br_taken = 1'b0;
   endtask

   task automatic look(input int addr, input bit exp_hit, input int line, input string what);
      lk_addr = AW'(addr);
      #1;
      chk(lk_hit == exp_hit, what, lk_hit, exp_hit);
      if (exp_hit) chk(lk_data == dat_of(line), what, lk_data, dat_of(line));
   endtask

   initial begin : wdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      int p1;
      // R1: reset state
      idle(1);
      #1;
      chk(probe_valid == 1'b0, "R1 probe in reset", probe_valid, 0);
      chk(req_valid == 1'b0, "R1 request in reset", req_valid, 0);
      rst_n = 1'b1;
      idle(1);
      chk(probe_valid == 1'b0, "R1 probe after reset", probe_valid, 0);
      look(0, 1'b0, 0, "R1 no hit after reset");

      // R2: burst, every line missing
      clear_log();
      do_hint(32'h123, 1'b0);
      idle(5);
      chk(nprobe == 2, "R2 burst probe count", nprobe, 2);
      chk(nreq == 2, "R2 burst request count", nreq, 2);
      chk(reqs[0] == 32'h120, "R2 burst first line", reqs[0], 32'h120);
      chk(reqs[1] == 32'h124, "R2 burst second line", reqs[1], 32'h124);

      // R2 R4 R6 R8 R9 R10: sweep of burst starts and cache patterns
      do_reset();
      for (int k = 0; k < 65; k++) begin
         int s;
         int ne;
         int el [2];
         s = (k == 64) ? NLINES - 1 : (k * 67) % NLINES;
         cmode = k % 4;
         clear_log();
         do_hint(s * LB + (k % LB), 1'b0);
         idle(4);
         ne = 0;
         for (int i = 0; i < 2; i++) begin
            int ln;
            ln = (s + i) % NLINES;
            if (!cached(ln)) begin
               el[ne] = ln;
               ne++;
            end
         end
         chk(nreq == ne, "R4 sweep request count", nreq, ne);
         for (int i = 0; i < ne; i++)
            chk(reqs[i] == el[i] * LB, "R10 sweep request address", reqs[i], el[i] * LB);
         for (int i = 0; i < ne; i++) ret_line(el[i]);
         for (int i = 0; i < 2; i++) begin
            int ln;
            ln = (s + i) % NLINES;
            look(ln * LB + 3, !cached(ln), ln, "R9 sweep lookup");
         end
         for (int i = 0; i < ne; i++) pop_one();
         idle(1);
         if (ne > 0) look(el[0] * LB, 1'b0, 0, "R8 released entry no hit");
      end

      // R3 R7 R8 R9: stream fills the buffer and stalls
      do_reset();
      cmode = 0;
      clear_log();
      do_hint(32'h200, 1'b1);
      idle(8);
      chk(nreq == DP, "R7 stream stalls when full", nreq, DP);
      chk(nprobe == DP, "R7 no probes while full", nprobe, DP);
      chk(reqs[3] == 32'h20C, "R3 stream fourth line", reqs[3], 32'h20C);
      look(32'h200, 1'b0, 0, "R9 unfilled entry no hit");
      pop_one();
      idle(3);
      chk(nreq == DP, "R8 pop of unfilled entry ignored", nreq, DP);
      ret_line(32'h80);
      look(32'h200, 1'b1, 32'h80, "R6 first return fills oldest");
      pop_one();
      idle(3);
      chk(nreq == DP + 1, "R7 resume after pop", nreq, DP + 1);
      chk(reqs[4] == 32'h210, "R7 resume address held", reqs[4], 32'h210);
      br_pulse();
      for (int i = 1; i < 5; i++) ret_line(32'h80 + i);
      look(32'h210, 1'b1, 32'h84, "R6 fifo fill order");
      look(32'h204, 1'b1, 32'h81, "R6 fifo fill order second");
      for (int i = 0; i < 4; i++) pop_one();
      idle(4);
      chk(nreq == DP + 1, "R3 stream ended by taken branch", nreq, DP + 1);

      // R3 R4: stream over cached lines, then taken branch
      do_reset();
      cmode = 3;
      clear_log();
      do_hint(32'h300, 1'b1);
      idle(4);
      br_pulse();
      idle(2);
      p1 = nprobe;
      idle(6);
      chk(p1 >= 4, "R3 stream kept probing", p1, 4);
      chk(nprobe == p1, "R3 no probe after taken branch", nprobe, p1);
      chk(nreq == 0, "R4 probe hit makes no request", nreq, 0);

      // R3: taken branch does not end a burst
      do_reset();
      cmode = 0;
      clear_log();
      @(negedge clk);
      hint_valid = 1'b1; hint_addr = AW'(32'h400); hint_stream = 1'b0;
      @(negedge clk);
      hint_valid = 1'b0; br_taken = 1'b1;
      @(negedge clk);
      br_taken = 1'b0;
      idle(4);
      chk(nreq == 2, "R3 burst ignores taken branch", nreq, 2);
      chk(reqs[1] == 32'h404, "R3 burst second line kept", reqs[1], 32'h404);

      // R5: new hint replaces an active stream
      do_reset();
      clear_log();
      do_hint(32'h500, 1'b1);
      do_hint(32'h700, 1'b0);
      idle(6);
      chk(nreq == 4, "R5 replacement request count", nreq, 4);
      chk(reqs[1] == 32'h504, "R5 stream before replacement", reqs[1], 32'h504);
      chk(reqs[2] == 32'h700, "R5 first line of new hint", reqs[2], 32'h700);
      chk(reqs[3] == 32'h704, "R5 second line of new hint", reqs[3], 32'h704);

      // R6 R9: stray return ignored, offset bits ignored on lookup
      do_reset();
      ret_line(5);
      clear_log();
      do_hint(32'h043, 1'b0);
      idle(4);
      ret_line(32'h10);
      ret_line(32'h11);
      look(32'h043, 1'b1, 32'h10, "R6 stray return ignored");
      look(32'h047, 1'b1, 32'h11, "R9 lookup ignores offset");
      look(32'h014, 1'b0, 0, "R6 stray line never stored");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule